// File: doc/BRIEF.md
# DMA Bank Extension Register Unit

This unit sits beside a four-channel DMA controller whose address counters are only 16 bits wide. It supplies each channel's upper address bits and joins them to the controller's 16-bit offset, which gives a full memory address per channel. A processor programs the bank bits with 8-bit I/O writes. The low-bank bytes can be read back.

There is a low bank byte for every channel. In the widest configuration there is also a high bank byte. A boundary register for each channel decides what happens when the controller reports that an offset has carried out of 16 bits. The transfer can wrap inside its 64 KB page. It can also carry into the lowest 4 or all 8 low-bank bits, which gives 1 MB or 16 MB reach. The parameter `ACFG` selects a 20-, 24- or 32-bit address configuration. A port that a configuration lacks is decoded as nothing.

Top module: `dma_bank_ext`

## Requirements
- R1: After synchronous reset, every low bank, high bank and boundary mask is zero, so each channel address equals its offset with zero upper bits.
- R2: A write to port 0x21, 0x23, 0x25 or 0x27 loads the low bank of channel 1, 2, 3 or 0 respectively, at the clock edge where `io_wr` is high.
- R3: `io_rdata` shows, without a clock, the low bank of the channel mapped to `io_addr` for ports 0x21/0x23/0x25/0x27, and 0xFF for every other address.
- R4: With `ACFG` = 20-bit, a low-bank write stores only data bits [3:0] and clears bits [7:4]. The 24-bit and 32-bit configurations store all 8 bits.
- R5: A write to port 0x29 (24/32-bit only) picks the channel with data[1:0] and the mode with data[3:2]. Mode 00 sets the mask to 0x00, mode 01 sets it to 0x0F and mode 11 sets it to 0xFF. Mode 10 leaves every mask unchanged.
- R6: When `dma_carry[ch]` is high, the low-bank bits of that channel that lie inside its mask count up by one, wrapping inside that field. Bits outside the mask do not change. A zero mask means no change.
- R7: With `ACFG` = 32-bit, a write to port 0xE05, 0xE07, 0xE09 or 0xE0B loads the high bank of channel 0, 1, 2 or 3.
- R8: A write to any other address has no effect. So do 0x29 and the 0xE0x ports in the 20-bit configuration, and the 0xE0x ports in the 24-bit configuration.
- R9: `bank_addr` holds a field of AW bits per channel, channel 0 lowest. The field is {low[3:0], offset} for 20-bit (AW=20), {low, offset} for 24-bit and {high, low, offset} for 32-bit.
- R10: When a low-bank write and a carry hit the same channel in the same cycle, the written value is stored and the carry is dropped. A carry in the same cycle as a 0x29 write uses the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | IO_AW | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| dma_ofs | input | NCH*16 | Per-channel 16-bit offsets from the DMA controller, channel 0 lowest |
| dma_carry | input | NCH | Per-channel offset carry-out pulse |
| bank_addr | output | NCH*AW | Per-channel full addresses, channel 0 lowest |

## Verification
The bench builds three copies side by side with `ACFG` set to 20-bit, 24-bit and 32-bit, and drives them with the same stimulus. An 8-bit bank makes it possible to sweep every value through every low-bank and high-bank port. The bench also steps the carry through every starting value in every boundary mode on every channel. The three copies show, from one stimulus, that the same write is stored, truncated or ignored depending on the configuration.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    typedef enum logic [1:0] {
        ACFG_20 = 2'd0,
        ACFG_24 = 2'd1,
        ACFG_32 = 2'd2
    } acfg_e;

    typedef enum logic [1:0] {
        BND_64K = 2'b00,
        BND_1M  = 2'b01,
        BND_RSV = 2'b10,
        BND_16M = 2'b11
    } bnd_e;

    localparam int BANK_W = 8;
    localparam int OFS_W  = 16;

    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        bank_t hi;
        bank_t lo;
        bank_t mask;
    } chan_state_t;

    function automatic int addr_width(acfg_e c);
        case (c)
            ACFG_20: return 20;
            ACFG_24: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic bank_t lo_keep(acfg_e c);
        return (c == ACFG_20) ? bank_t'(8'h0F) : bank_t'(8'hFF);
    endfunction

    function automatic bank_t bnd_mask_of(bnd_e m);
        case (m)
            BND_1M:  return bank_t'(8'h0F);
            BND_16M: return bank_t'(8'hFF);
            default: return bank_t'(8'h00);
        endcase
    endfunction

    // Count up only the bits under the mask; carry cannot leave the field.
    function automatic bank_t bank_step(bank_t b, bank_t m);
        return (b & ~m) | ((b + bank_t'(1)) & m);
    endfunction

endpackage

// File: rtl/dmab_io_decode.sv
module dmab_io_decode
    import dmab_pkg::*;
#(
    parameter acfg_e ACFG      = ACFG_32,
    parameter int    NCH       = 4,
    parameter int    IO_AW     = 16,
    parameter int    LO_BASE   = 'h0021,
    parameter int    HI_BASE   = 'h0E05,
    parameter int    BND_PORT  = 'h0029,
    parameter int    PORT_STEP = 2,
    localparam int   CHW       = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [NCH-1:0]   lo_we,
    output logic [NCH-1:0]   hi_we,
    output logic [NCH-1:0]   bnd_we,
    output bank_t            bnd_mask,
    output logic             rd_hit,
    output logic [CHW-1:0]   rd_chan
);

    logic [CHW-1:0] bnd_sel;
    bnd_e           bnd_mode;
    logic           bnd_hit;
    logic           bnd_ok;

    assign bnd_sel  = io_wdata[CHW-1:0];
    assign bnd_mode = bnd_e'(io_wdata[CHW+1:CHW]);
    assign bnd_hit  = (io_addr == IO_AW'(BND_PORT));
    assign bnd_ok   = (ACFG != ACFG_20) && io_wr && bnd_hit && (bnd_mode != BND_RSV);
    assign bnd_mask = bnd_mask_of(bnd_mode);

    generate
        if (CHW + 2 < 8) begin : g_unused_data
            logic unused_wdata;
            assign unused_wdata = ^io_wdata[7:CHW+2];
        end
    endgenerate

    // Low-bank ports are rotated: port k serves channel (k+1) mod NCH.
    always_comb begin
        lo_we   = '0;
        rd_hit  = 1'b0;
        rd_chan = '0;
        for (int k = 0; k < NCH; k++) begin
            if (io_addr == IO_AW'(LO_BASE + k * PORT_STEP)) begin
                lo_we[(k + 1) % NCH] = io_wr;
                rd_hit               = 1'b1;
                rd_chan              = CHW'((k + 1) % NCH);
            end
        end
    end

    always_comb begin
        hi_we = '0;
        if (ACFG == ACFG_32) begin
            for (int k = 0; k < NCH; k++) begin
                if (io_addr == IO_AW'(HI_BASE + k * PORT_STEP)) hi_we[k] = io_wr;
            end
        end
    end

    always_comb begin
        bnd_we = '0;
        for (int k = 0; k < NCH; k++) begin
            if (bnd_ok && (bnd_sel == CHW'(k))) bnd_we[k] = 1'b1;
        end
    end

    a_r2_lo_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lo_we));

    a_r7_hi_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hi_we));

    a_r5_reserved_mode: assert property (@(posedge clk) disable iff (rst)
        (bnd_hit && io_wdata[CHW+1:CHW] == 2'b10) |-> (bnd_we == '0));

    a_r3_no_write_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !io_wr |-> ((lo_we | hi_we | bnd_we) == '0));

endmodule

// File: rtl/dmab_bank_chan.sv
module dmab_bank_chan
    import dmab_pkg::*;
#(
    parameter acfg_e ACFG = ACFG_32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  lo_we,
    input  logic  hi_we,
    input  logic  bnd_we,
    input  bank_t wdata,
    input  bank_t bnd_mask,
    input  logic  carry,
    output chan_state_t st
);

    localparam bank_t KEEP = lo_keep(ACFG);

    bank_t lo_q;
    bank_t mask_q;
    bank_t hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            mask_q <= '0;
        end else begin
            if (lo_we)       lo_q <= wdata & KEEP;
            else if (carry)  lo_q <= bank_step(lo_q, mask_q);
            if (bnd_we)      mask_q <= bnd_mask;
        end
    end

    generate
        if (ACFG == ACFG_32) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst)        hi_q <= '0;
                else if (hi_we) hi_q <= wdata;
            end
        end else begin : g_no_hi
            logic unused_hi_we;
            assign unused_hi_we = hi_we;
            assign hi_q = '0;
        end
    endgenerate

    assign st.lo   = lo_q;
    assign st.hi   = hi_q;
    assign st.mask = mask_q;

    a_r6_outside_mask_held: assert property (@(posedge clk) disable iff (rst)
        (carry && !lo_we) |=> (((lo_q ^ $past(lo_q)) & ~$past(mask_q)) == '0));

    a_r6_zero_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (carry && !lo_we && mask_q == '0) |=> $stable(lo_q));

    a_r5_mask_shape: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 8'h00) || (mask_q == 8'h0F) || (mask_q == 8'hFF));

    a_r4_narrow_low: assert property (@(posedge clk) disable iff (rst)
        (ACFG == ACFG_20) |-> (lo_q[7:4] == 4'h0));

    a_r10_write_beats_carry: assert property (@(posedge clk) disable iff (rst)
        (lo_we && carry) |=> (lo_q == ($past(wdata) & KEEP)));

endmodule

// File: rtl/dma_bank_ext.sv
module dma_bank_ext
    import dmab_pkg::*;
#(
    parameter acfg_e ACFG  = ACFG_32,
    parameter int    NCH   = 4,
    parameter int    IO_AW = 16,
    localparam int   AW    = addr_width(ACFG),
    localparam int   CHW   = $clog2(NCH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic [IO_AW-1:0]     io_addr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic [NCH*OFS_W-1:0] dma_ofs,
    input  logic [NCH-1:0]       dma_carry,
    output logic [NCH*AW-1:0]    bank_addr
);

    logic [NCH-1:0] lo_we;
    logic [NCH-1:0] hi_we;
    logic [NCH-1:0] bnd_we;
    bank_t          bnd_mask;
    logic           rd_hit;
    logic [CHW-1:0] rd_chan;
    chan_state_t    st [NCH];

    dmab_io_decode #(
        .ACFG (ACFG),
        .NCH  (NCH),
        .IO_AW(IO_AW)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .bnd_we  (bnd_we),
        .bnd_mask(bnd_mask),
        .rd_hit  (rd_hit),
        .rd_chan (rd_chan)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            logic [OFS_W-1:0] ofs;
            assign ofs = dma_ofs[ch*OFS_W +: OFS_W];

            dmab_bank_chan #(.ACFG(ACFG)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .lo_we   (lo_we[ch]),
                .hi_we   (hi_we[ch]),
                .bnd_we  (bnd_we[ch]),
                .wdata   (io_wdata),
                .bnd_mask(bnd_mask),
                .carry   (dma_carry[ch]),
                .st      (st[ch])
            );

            logic unused_mask;
            assign unused_mask = ^st[ch].mask;

            if (ACFG == ACFG_20) begin : g_a20
                logic unused_up;
                assign unused_up = ^{st[ch].hi, st[ch].lo[7:4]};
                assign bank_addr[ch*AW +: AW] = {st[ch].lo[3:0], ofs};
            end else if (ACFG == ACFG_24) begin : g_a24
                logic unused_up;
                assign unused_up = ^st[ch].hi;
                assign bank_addr[ch*AW +: AW] = {st[ch].lo, ofs};
            end else begin : g_a32
                assign bank_addr[ch*AW +: AW] = {st[ch].hi, st[ch].lo, ofs};
            end
        end
    endgenerate

    assign io_rdata = rd_hit ? st[rd_chan].lo : 8'hFF;

    a_r3_unmapped_reads_ff: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (io_rdata == 8'hFF));

endmodule

// File: tb/sim_dma_bank_ext.sv
`timescale 1ns/1ps
module sim_dma_bank_ext;
    import dmab_pkg::*;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         io_wr = 1'b0;
    logic [15:0]  io_addr = 16'h0000;
    logic [7:0]   io_wdata = 8'h00;
    logic [63:0]  dma_ofs = '0;
    logic [3:0]   dma_carry = '0;

    logic [7:0]   rd20, rd24, rd32;
    logic [79:0]  a20;
    logic [95:0]  a24;
    logic [127:0] a32;

    always #2 clk = ~clk;

    dma_bank_ext #(.ACFG(ACFG_32)) u0 (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(rd32), .dma_ofs(dma_ofs), .dma_carry(dma_carry), .bank_addr(a32));
    dma_bank_ext #(.ACFG(ACFG_24)) u1 (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(rd24), .dma_ofs(dma_ofs), .dma_carry(dma_carry), .bank_addr(a24));
    dma_bank_ext #(.ACFG(ACFG_20)) u2 (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(rd20), .dma_ofs(dma_ofs), .dma_carry(dma_carry), .bank_addr(a20));

    // model: index 0 = 20-bit, 1 = 24-bit, 2 = 32-bit
    int m_lo   [3][4];
    int m_hi   [3][4];
    int m_mask [3][4];

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic cmp(string tag, int cfg, int ch, longint got, longint exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s cfg%0d ch%0d: actual %h expected %h", tag, cfg, ch, got, exp);
        end
    endtask

    function automatic int step_model(int lo, int m);
        int fld;
        if (m == 0) return lo;
        fld = lo & m;
        return (lo - fld) + ((fld + 1) % (m + 1));
    endfunction

    task automatic model_update(bit wr, int addr, int data, logic [3:0] cy);
        for (int c = 0; c < 3; c++) begin
            int wch = -1;
            if (wr) begin
                for (int k = 0; k < 4; k++)
                    if (addr == 'h21 + 2 * k) wch = (k + 1) % 4;
            end
            for (int ch = 0; ch < 4; ch++)
                if (cy[ch] && ch != wch) m_lo[c][ch] = step_model(m_lo[c][ch], m_mask[c][ch]);
            if (wr) begin
                if (wch >= 0) m_lo[c][wch] = (c == 0) ? (data % 16) : data;
                for (int k = 0; k < 4; k++)
                    if (c == 2 && addr == 'hE05 + 2 * k) m_hi[c][k] = data;
                if (c > 0 && addr == 'h29) begin
                    case ((data / 4) % 4)
                        0: m_mask[c][data % 4] = 'h00;
                        1: m_mask[c][data % 4] = 'h0F;
                        3: m_mask[c][data % 4] = 'hFF;
                        default: ;
                    endcase
                end
            end
        end
    endtask

    // one clock: drive after the falling edge, update model at the rising edge
    task automatic step(bit wr, int addr, int data, logic [3:0] cy);
        @(negedge clk);
        io_wr     = wr;
        io_addr   = addr[15:0];
        io_wdata  = data[7:0];
        dma_carry = cy;
        @(posedge clk);
        model_update(wr, addr, data, cy);
        #1;
        io_wr     = 1'b0;
        dma_carry = '0;
    endtask

    task automatic check_addr(string tag);
        @(negedge clk);
        for (int ch = 0; ch < 4; ch++) begin
            longint ofs = longint'(dma_ofs[ch*16 +: 16]);
            cmp(tag, 0, ch, longint'(a20[ch*20 +: 20]), (m_lo[0][ch] % 16) * 65536 + ofs);
            cmp(tag, 1, ch, longint'(a24[ch*24 +: 24]), m_lo[1][ch] * 65536 + ofs);
            cmp(tag, 2, ch, longint'(a32[ch*32 +: 32]),
                longint'(m_hi[2][ch]) * 16777216 + longint'(m_lo[2][ch]) * 65536 + ofs);
        end
    endtask

    task automatic check_read(string tag, int addr);
        int ch = -1;
        @(negedge clk);
        io_addr = addr[15:0];
        #1;
        for (int k = 0; k < 4; k++) if (addr == 'h21 + 2 * k) ch = (k + 1) % 4;
        cmp(tag, 0, ch, longint'(rd20), (ch < 0) ? 'hFF : m_lo[0][ch]);
        cmp(tag, 1, ch, longint'(rd24), (ch < 0) ? 'hFF : m_lo[1][ch]);
        cmp(tag, 2, ch, longint'(rd32), (ch < 0) ? 'hFF : m_lo[2][ch]);
    endtask

    task automatic set_ofs(int seed);
        for (int ch = 0; ch < 4; ch++)
            dma_ofs[ch*16 +: 16] = 16'((seed * 331 + ch * 'h1111 + 7) % 65536);
    endtask

    initial begin
        for (int c = 0; c < 3; c++)
            for (int ch = 0; ch < 4; ch++) begin
                m_lo[c][ch] = 0; m_hi[c][ch] = 0; m_mask[c][ch] = 0;
            end
        set_ofs(1);
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state visible on addresses and reads
        check_addr("R1");
        for (int k = 0; k < 4; k++) check_read("R1", 'h21 + 2 * k);

        // R2, R4, R9: every value through every low-bank port
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 4; k++) begin
                set_ofs(v * 4 + k);
                step(1'b1, 'h21 + 2 * k, (v + k * 37) % 256, 4'h0);
                check_addr("R2");
            end
            if (v % 32 == 5)
                for (int k = 0; k < 4; k++) check_read("R4", 'h21 + 2 * k);
        end

        // R7, R8: high-bank ports (stored only in 32-bit)
        for (int v = 0; v < 256; v += 3) begin
            for (int k = 0; k < 4; k++) step(1'b1, 'hE05 + 2 * k, (v + 50 * k) % 256, 4'h0);
            check_addr("R7");
        end

        // R3: unmapped addresses read back 0xFF
        check_read("R3", 'h20);
        check_read("R3", 'h22);
        check_read("R3", 'h29);
        check_read("R3", 'hE05);
        check_read("R3", 'h0121);
        for (int k = 0; k < 4; k++) check_read("R3", 'h21 + 2 * k);

        // R8: writes to neighbouring and aliasing addresses change nothing
        step(1'b1, 'h20, 'h5A, 4'h0);
        step(1'b1, 'h22, 'h5A, 4'h0);
        step(1'b1, 'h28, 'h0F, 4'h0);
        step(1'b1, 'hE04, 'h5A, 4'h0);
        step(1'b1, 'h0121, 'h5A, 4'h0);
        step(1'b1, 'hE0D, 'h5A, 4'h0);
        check_addr("R8");
        for (int k = 0; k < 4; k++) check_read("R8", 'h21 + 2 * k);

        // R5, R6: every mode, every channel, every starting value, one carry
        for (int mode = 0; mode < 4; mode++) begin
            for (int ch = 0; ch < 4; ch++) begin
                step(1'b1, 'h29, mode * 4 + ch, 4'h0);
                for (int v = 0; v < 256; v++) begin
                    step(1'b1, 'h21 + 2 * ((ch + 3) % 4), v, 4'h0);
                    step(1'b0, 0, 0, 4'(1 << ch));
                    check_addr((mode == 2) ? "R5" : "R6");
                end
            end
        end

        // R5: reserved mode 10 after a 16 MB setting leaves the mask in place
        for (int ch = 0; ch < 4; ch++) step(1'b1, 'h29, 'hC + ch, 4'h0);
        for (int ch = 0; ch < 4; ch++) step(1'b1, 'h29, 'h8 + ch, 4'h0);
        for (int ch = 0; ch < 4; ch++) step(1'b1, 'h21 + 2 * ((ch + 3) % 4), 'hFF, 4'h0);
        step(1'b0, 0, 0, 4'hF);
        check_addr("R5");
        // R8: upper data bits of the boundary write are ignored apart from the fields
        step(1'b1, 'h29, 'hF4 + 1, 4'h0);
        for (int v = 0; v < 40; v++) begin
            step(1'b0, 0, 0, 4'hF);
            check_addr("R6");
        end

        // R10: write and carry on the same channel in the same cycle
        for (int v = 0; v < 64; v++) begin
            step(1'b1, 'h21 + 2 * (v % 4), v * 3, 4'hF);
            check_addr("R10");
            step(1'b1, 'h29, ((v % 3 == 2) ? 3 : v % 3) * 4 + (v % 4), 4'hF);
            check_addr("R10");
        end
        for (int k = 0; k < 4; k++) check_read("R10", 'h21 + 2 * k);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule